// File: doc/BRIEF.md
# Inverse-Time Overcurrent Timing Element

This block is the timing core of an inverse-time overcurrent protection element. On every sample strobe it takes a precomputed unsigned current magnitude, compares it with a programmable pickup level, and gates the result with an external torque-control enable. While the element is picked up, an accumulator integrates toward a trip level. The rate is set by a selected curve, the multiple of pickup reached by the current, and a time dial. Larger currents and smaller dial settings trip sooner.

When the element drops out, the accumulator either clears at once or winds down at a curve-dependent rate, which mimics an electromechanical disc. A rest flag reports when the accumulator is back at zero. A force input returns the element to rest without delay, so a bench does not have to wait out a slow wind-down.

Top module: `itoc_element`

## Requirements
- R1: On a strobe, pickup_o becomes 1 only when cur_mag is strictly greater than pk_set and torque_en is 1. When cur_mag equals pk_set, pickup_o is 0.
- R2: When smp_vld is 0 and force_rest is 0, changes on the other inputs have no effect, and all three outputs hold their values.
- R3: The pickup multiple bin is the number of shifts i in 1..NUM_BINS-1 for which cur_mag >= pk_set<<i. Each picked-up strobe adds (1 << bin*(crv_sel+1)) * (2^DIAL_W - dial_set) to the accumulator. timed_out_o asserts when the accumulator reaches 2^ACC_W-1.
- R4: The accumulator saturates at the trip level and does not wrap, so timed_out_o stays 1 on further picked-up strobes.
- R5: A higher multiple of pickup selects a larger increment. For example, curve 1 at bin 1 with dial 8 trips in 128 strobes.
- R6: timed_out_o falls on the same strobe on which pickup_o falls.
- R7: With rst_mode 0 (instantaneous), the first strobe that is not picked up clears the accumulator, and rest_done_o becomes 1.
- R8: With rst_mode 1 (electromechanical), each strobe that is not picked up subtracts (crv_sel+1)<<RST_SH from the accumulator, floored at zero.
- R9: rest_done_o is 1 exactly when the accumulator is zero. It is 0 after a single picked-up strobe.
- R10: When torque_en is 0 and the current is above pickup, the element behaves as it does below pickup and follows the selected reset mode.
- R11: force_rest clears the accumulator and pickup on the next clock edge, whether or not a strobe is present. After that edge, rest_done_o=1, pickup_o=0 and timed_out_o=0.
- R12: After reset, pickup_o=0, timed_out_o=0 and rest_done_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | One-cycle sample strobe |
| cur_mag | input | MAG_W | Current magnitude sample |
| pk_set | input | MAG_W | Pickup level |
| crv_sel | input | CRV_W | Curve selection |
| dial_set | input | DIAL_W | Time dial (larger is slower) |
| rst_mode | input | 1 | 0 instantaneous reset, 1 electromechanical reset |
| torque_en | input | 1 | Torque-control enable |
| force_rest | input | 1 | Force element to rest |
| pickup_o | output | 1 | Picked up |
| timed_out_o | output | 1 | Curve timed out |
| rest_done_o | output | 1 | Accumulator at rest (zero) |

## Verification
Currents at, just above and at several multiples of pickup are applied. These inputs separate a strict comparison from a loose one and show whether the bin quantizer picks the right curve increment. The exact strobe on which the trip occurs, one before and one after, exposes off-by-one and wrap errors in the saturating accumulator. Dropout is tried in both reset modes, through both a falling current and a falling torque enable, and the rest flag is checked one strobe before and on the strobe of completion. Forced rest and idle cycles without a strobe show that only the proper controls change state.

// File: rtl/itoc_pkg.sv
package itoc_pkg;
   typedef enum logic {
      RST_INSTANT = 1'b0,
      RST_EMULATE = 1'b1
   } itoc_rst_e;
endpackage

// File: rtl/itoc_binner.sv
module itoc_binner #(
   parameter int MAG_W    = 16,
   parameter int NUM_BINS = 4,
   localparam int BIN_W   = $clog2(NUM_BINS)
) (
   input  logic [MAG_W-1:0] mag,
   input  logic [MAG_W-1:0] pk,
   output logic             over,
   output logic [BIN_W-1:0] bin
);
   localparam int WIDE_W = MAG_W + NUM_BINS;

   logic [NUM_BINS-1:0] ge;

   assign over  = mag > pk;
   assign ge[0] = 1'b0;

   for (genvar gi = 1; gi < NUM_BINS; gi++) begin : g_thr
      assign ge[gi] = WIDE_W'(mag) >= (WIDE_W'(pk) << gi);
   end

   always_comb begin
      bin = '0;
      for (int i = 1; i < NUM_BINS; i++) begin
         bin = bin + BIN_W'(ge[i]);
      end
   end
endmodule

// File: rtl/itoc_curve.sv
module itoc_curve #(
   parameter int CRV_W    = 2,
   parameter int DIAL_W   = 4,
   parameter int NUM_BINS = 4,
   localparam int BIN_W   = $clog2(NUM_BINS),
   localparam int MAX_SH  = (NUM_BINS - 1) * (2 ** CRV_W),
   localparam int BASE_W  = MAX_SH + 1,
   localparam int INC_W   = BASE_W + DIAL_W + 1
) (
   input  logic [CRV_W-1:0]  crv,
   input  logic [BIN_W-1:0]  bin,
   input  logic [DIAL_W-1:0] dial,
   output logic [INC_W-1:0]  inc
);
   localparam int SH_W = $clog2(MAX_SH + 1);

   logic [SH_W-1:0]   sh;
   logic [BASE_W-1:0] base;
   logic [DIAL_W:0]   mult;

   always_comb begin
      sh   = SH_W'(SH_W'(bin) * (SH_W'(crv) + SH_W'(1)));
      base = BASE_W'(1) << sh;
      mult = (DIAL_W+1)'(2 ** DIAL_W) - (DIAL_W+1)'(dial);
      inc  = INC_W'(base) * INC_W'(mult);
   end
endmodule

// File: rtl/itoc_integrator.sv
module itoc_integrator
   import itoc_pkg::*;
#(
   parameter int ACC_W  = 12,
   parameter int CRV_W  = 2,
   parameter int INC_W  = 18,
   parameter int RST_SH = 2,
   localparam int SUM_W = ACC_W + INC_W + 1,
   localparam logic [ACC_W-1:0] TRIP = {ACC_W{1'b1}}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld,
   input  logic             frc,
   input  logic             pick,
   input  itoc_rst_e        mode,
   input  logic [CRV_W-1:0] crv,
   input  logic [INC_W-1:0] inc,
   output logic             pu_q,
   output logic             tmo,
   output logic             rest
);
   logic [ACC_W-1:0] acc_q, acc_up, acc_dn, dec;
   logic [SUM_W-1:0] sum;

   always_comb begin
      sum    = SUM_W'(acc_q) + SUM_W'(inc);
      acc_up = (sum >= SUM_W'(TRIP)) ? TRIP : sum[ACC_W-1:0];
      dec    = (ACC_W'(crv) + ACC_W'(1)) << RST_SH;
      acc_dn = (acc_q > dec) ? acc_q - dec : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         pu_q  <= 1'b0;
      end else if (frc) begin
         acc_q <= '0;
         pu_q  <= 1'b0;
      end else if (vld) begin
         pu_q <= pick;
         if (pick)                    acc_q <= acc_up;
         else if (mode == RST_EMULATE) acc_q <= acc_dn;
         else                          acc_q <= '0;
      end
   end

   assign tmo  = pu_q && (acc_q == TRIP);
   assign rest = (acc_q == '0);
endmodule

// File: rtl/itoc_element.sv
module itoc_element
   import itoc_pkg::*;
#(
   parameter int MAG_W    = 16,
   parameter int ACC_W    = 12,
   parameter int DIAL_W   = 4,
   parameter int CRV_W    = 2,
   parameter int NUM_BINS = 4,
   parameter int RST_SH   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_vld,
   input  logic [MAG_W-1:0]  cur_mag,
   input  logic [MAG_W-1:0]  pk_set,
   input  logic [CRV_W-1:0]  crv_sel,
   input  logic [DIAL_W-1:0] dial_set,
   input  logic              rst_mode,
   input  logic              torque_en,
   input  logic              force_rest,
   output logic              pickup_o,
   output logic              timed_out_o,
   output logic              rest_done_o
);
   localparam int BIN_W  = $clog2(NUM_BINS);
   localparam int MAX_SH = (NUM_BINS - 1) * (2 ** CRV_W);
   localparam int INC_W  = MAX_SH + 1 + DIAL_W + 1;

   initial begin
      assert (NUM_BINS >= 2) else $error("NUM_BINS must be at least 2");
      assert (ACC_W >= 4)    else $error("ACC_W too small");
      assert (RST_SH < ACC_W) else $error("RST_SH must be below ACC_W");
   end

   logic             over, pick;
   logic [BIN_W-1:0] bin;
   logic [INC_W-1:0] inc;

   itoc_binner #(.MAG_W(MAG_W), .NUM_BINS(NUM_BINS)) u_bin (
      .mag (cur_mag),
      .pk  (pk_set),
      .over(over),
      .bin (bin)
   );

   itoc_curve #(.CRV_W(CRV_W), .DIAL_W(DIAL_W), .NUM_BINS(NUM_BINS)) u_crv (
      .crv (crv_sel),
      .bin (bin),
      .dial(dial_set),
      .inc (inc)
   );

   assign pick = over && torque_en;

   itoc_integrator #(.ACC_W(ACC_W), .CRV_W(CRV_W), .INC_W(INC_W), .RST_SH(RST_SH)) u_int (
      .clk  (clk),
      .rst_n(rst_n),
      .vld  (smp_vld),
      .frc  (force_rest),
      .pick (pick),
      .mode (itoc_rst_e'(rst_mode)),
      .crv  (crv_sel),
      .inc  (inc),
      .pu_q (pickup_o),
      .tmo  (timed_out_o),
      .rest (rest_done_o)
   );
endmodule

// File: rtl/itoc_element_chk.sv
module itoc_element_chk #(
   parameter int MAG_W  = 16,
   parameter int DIAL_W = 4,
   parameter int CRV_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              smp_vld,
   input logic [MAG_W-1:0]  cur_mag,
   input logic [MAG_W-1:0]  pk_set,
   input logic [CRV_W-1:0]  crv_sel,
   input logic [DIAL_W-1:0] dial_set,
   input logic              rst_mode,
   input logic              torque_en,
   input logic              force_rest,
   input logic              pickup_o,
   input logic              timed_out_o,
   input logic              rest_done_o
);
   logic live;
   assign live = cur_mag > pk_set && torque_en;

   assert_pickup_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && !force_rest) |=> (pickup_o == $past(live)));

   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_vld && !force_rest) |=> ($stable(pickup_o) && $stable(timed_out_o) && $stable(rest_done_o)));

   assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && !force_rest && timed_out_o && live) |=> timed_out_o);

   assert_tmo_needs_pickup_R6: assert property (@(posedge clk) disable iff (!rst_n)
      timed_out_o |-> pickup_o);

   assert_instant_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && !force_rest && !live && !rst_mode) |=> rest_done_o);

   assert_rest_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rest_done_o |-> !timed_out_o);

   assert_force_rest_R11: assert property (@(posedge clk) disable iff (!rst_n)
      force_rest |=> (rest_done_o && !pickup_o && !timed_out_o));
endmodule

bind itoc_element itoc_element_chk #(.MAG_W(MAG_W), .DIAL_W(DIAL_W), .CRV_W(CRV_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .cur_mag(cur_mag), .pk_set(pk_set),
   .crv_sel(crv_sel), .dial_set(dial_set), .rst_mode(rst_mode), .torque_en(torque_en),
   .force_rest(force_rest), .pickup_o(pickup_o), .timed_out_o(timed_out_o),
   .rest_done_o(rest_done_o)
);

// File: tb/sim_itoc_element.sv
module sim_itoc_element;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_vld = 1'b0;
   logic [15:0] cur_mag = '0;
   logic [15:0] pk_set = 16'd100;
   logic [1:0]  crv_sel = '0;
   logic [3:0]  dial_set = '0;
   logic        rst_mode = 1'b0;
   logic        torque_en = 1'b1;
   logic        force_rest = 1'b0;
   logic        pickup_o, timed_out_o, rest_done_o;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   itoc_element u0 (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .cur_mag(cur_mag), .pk_set(pk_set),
      .crv_sel(crv_sel), .dial_set(dial_set), .rst_mode(rst_mode), .torque_en(torque_en),
      .force_rest(force_rest), .pickup_o(pickup_o), .timed_out_o(timed_out_o),
      .rest_done_o(rest_done_o)
   );

   task automatic chk(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic strobe(input int n);
      @(negedge clk);
      smp_vld = 1'b1;
      repeat (n) @(negedge clk);
      smp_vld = 1'b0;
   endtask

   task automatic do_force();
      @(negedge clk);
      force_rest = 1'b1;
      @(negedge clk);
      force_rest = 1'b0;
   endtask

   task automatic t_reset();
      chk(pickup_o, 1'b0, "R12 pickup after reset");
      chk(timed_out_o, 1'b0, "R12 timed_out after reset");
      chk(rest_done_o, 1'b1, "R12 rest after reset");
   endtask

   task automatic t_pickup();
      rst_mode = 1'b0; cur_mag = 16'd100; torque_en = 1'b1;
      strobe(1);
      chk(pickup_o, 1'b0, "R1 equal to pickup");
      chk(rest_done_o, 1'b1, "R1 equal leaves rest");
      cur_mag = 16'd101;
      strobe(1);
      chk(pickup_o, 1'b1, "R1 above pickup");
      chk(rest_done_o, 1'b0, "R9 nonzero accumulator");
      torque_en = 1'b0;
      strobe(1);
      chk(pickup_o, 1'b0, "R10 torque off drops pickup");
      chk(rest_done_o, 1'b1, "R10 instant reset via torque");
      torque_en = 1'b1;
   endtask

   task automatic t_hold_force();
      cur_mag = 16'd150;
      strobe(1);
      chk(pickup_o, 1'b1, "R2 setup pickup");
      @(negedge clk);
      cur_mag = 16'd0; torque_en = 1'b0; rst_mode = 1'b0;
      repeat (5) @(negedge clk);
      chk(pickup_o, 1'b1, "R2 pickup held without strobe");
      chk(rest_done_o, 1'b0, "R2 accumulator held without strobe");
      do_force();
      chk(rest_done_o, 1'b1, "R11 force gives rest");
      chk(pickup_o, 1'b0, "R11 force clears pickup");
      torque_en = 1'b1;
   endtask

   task automatic t_trip_base();
      crv_sel = 2'd0; dial_set = 4'd0; cur_mag = 16'd150; rst_mode = 1'b0;
      strobe(255);
      chk(timed_out_o, 1'b0, "R3 not timed out at 255");
      strobe(1);
      chk(timed_out_o, 1'b1, "R3 timed out at 256");
      strobe(5);
      chk(timed_out_o, 1'b1, "R4 saturates without wrap");
      cur_mag = 16'd50;
      strobe(1);
      chk(timed_out_o, 1'b0, "R6 timed_out drops with pickup");
      chk(pickup_o, 1'b0, "R6 pickup dropped");
      chk(rest_done_o, 1'b1, "R7 instant reset clears");
   endtask

   task automatic t_trip_bin();
      crv_sel = 2'd1; dial_set = 4'd8; cur_mag = 16'd250;
      strobe(127);
      chk(timed_out_o, 1'b0, "R5 bin1 curve1 not at 127");
      strobe(1);
      chk(timed_out_o, 1'b1, "R5 bin1 curve1 at 128");
      do_force();
      chk(timed_out_o, 1'b0, "R11 force clears timed_out");
      chk(rest_done_o, 1'b1, "R11 force rest after trip");
   endtask

   task automatic t_em_reset();
      crv_sel = 2'd0; dial_set = 4'd0; cur_mag = 16'd150; rst_mode = 1'b1;
      strobe(256);
      chk(timed_out_o, 1'b1, "R8 setup trip");
      cur_mag = 16'd50;
      strobe(1023);
      chk(rest_done_o, 1'b0, "R8 still winding at 1023");
      chk(timed_out_o, 1'b0, "R6 timed_out off during wind-down");
      strobe(1);
      chk(rest_done_o, 1'b1, "R8 rest at 1024");
   endtask

   task automatic t_torque_em();
      crv_sel = 2'd0; dial_set = 4'd0; cur_mag = 16'd150; rst_mode = 1'b1;
      strobe(10);
      torque_en = 1'b0;
      strobe(1);
      chk(pickup_o, 1'b0, "R10 torque off drops pickup");
      chk(rest_done_o, 1'b0, "R10 electromechanical wind-down");
      strobe(38);
      chk(rest_done_o, 1'b0, "R10 not rest at 39");
      strobe(1);
      chk(rest_done_o, 1'b1, "R10 rest at 40");
      torque_en = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pickup();
      t_hold_force();
      t_trip_base();
      t_trip_bin();
      t_em_reset();
      t_torque_em();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 4);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule